// File: doc/BRIEF.md
# Register Range Transfer Sequencer with Stack Mode

This block moves a contiguous, possibly wrapping range of 32-bit registers between a register file and memory. It moves one full word per memory beat. A start strobe gives the direction (load or store), the first and last register indices and a base-register select. When a nonzero base is selected, the transfer begins at that base value plus an offset. When base register zero is selected, that register acts as a stack pointer. A store then becomes a push: the words are written from the pointer upward, and the pointer then grows by the number of bytes written. A load becomes a pop: the pointer first shrinks by the number of bytes to read, and the words are then read from the new pointer upward.

The sequencer reads the register file through an asynchronous read port and writes it through a write port that is qualified in the acknowledge cycle. It talks to memory through a request/acknowledge handshake that holds every request until it is acknowledged. The surrounding core supplies the selected base value and the current stack pointer. The core receives a single-cycle done strobe, together with an optional stack-pointer write.

Top module: `lsm_seq`

## Requirements
- R1: A transfer moves ((last - first) mod 16) + 1 registers, one memory beat each, in ascending register index order; after index 15 the order continues at index 0.
- R2: Beat k of a transfer uses address start + 4*k. With a nonzero base select, start is base_val + offset and the stack pointer is never written.
- R3: A store with base_sel = 0 starts at sp_val. At completion the stack pointer is written with sp_val + 4*count.
- R4: A load with base_sel = 0 starts at sp_val - 4*count. At completion the stack pointer is written with that same value.
- R5: When base_sel = 0 the offset input has no effect on addresses or on the new stack pointer.
- R6: Each beat issues exactly one request. The request, its address and its direction stay steady until mem_ack is seen.
- R7: done is high for exactly one cycle, the cycle after the last beat is acknowledged. sp_we is asserted only in that cycle.
- R8: Start addresses that are not multiples of 4 are used unchanged, and the transfer completes normally.
- R9: On a load, the acknowledged beat writes mem_rdata into the register being moved. On a store, the register's contents become mem_wdata and land in memory, so a push followed by a pop of the same range restores the same values.
- R10: A start strobe that arrives while a transfer is in progress is ignored.
- R11: After reset, or a reset in mid-transfer, the block is idle, with no request, no done pulse and no register or pointer write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transfer (taken only when idle) |
| is_load | input | 1 | 1 = memory to registers, 0 = registers to memory |
| first_idx | input | 4 | First register of the range |
| last_idx | input | 4 | Last register of the range |
| base_sel | input | 4 | Base register select; 0 selects stack mode |
| base_val | input | 32 | Contents of the selected nonzero base register |
| offset | input | 32 | Address offset added to base_val |
| sp_val | input | 32 | Current stack pointer (base register zero) |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion strobe |
| sp_we | output | 1 | Stack pointer write enable |
| sp_wdata | output | 32 | New stack pointer value |
| rf_raddr | output | 4 | Register file read index |
| rf_rdata | input | 32 | Register file read data |
| rf_we | output | 1 | Register file write enable |
| rf_waddr | output | 4 | Register file write index |
| rf_wdata | output | 32 | Register file write data |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | 32 | Byte address of the beat |
| mem_wdata | output | 32 | Store data |
| mem_rdata | input | 32 | Load data, valid with mem_ack |
| mem_ack | input | 1 | Memory acknowledge |

## Verification
The main function is tried with plain base-plus-offset transfers, including a negative offset, and with pushes and pops over the same ranges, so that addressing before and after the pointer moves can be told apart. Ranges cover a single register, a partial span, a full sixteen-register span and spans that wrap past index 15. These expose count and ordering faults. Aligned and unaligned pointers are mixed, and the memory latency varies from zero to two wait cycles. Under that latency, the hold-until-acknowledge rule is tested against an early advance. A pop that follows a push over a wrapping range checks that the data goes there and back, not only the addresses.

// File: rtl/lsm_pkg.sv
package lsm_pkg;
    localparam int NREG       = 16;
    localparam int IDX_W      = $clog2(NREG);
    localparam int DW         = 32;
    localparam int AW         = 32;
    localparam int WORD_BYTES = DW / 8;
    localparam int CNT_W      = IDX_W + 1;

    typedef logic [IDX_W-1:0] idx_t;
    typedef logic [AW-1:0]    addr_t;
    typedef logic [DW-1:0]    word_t;
    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_MOVE = 2'd1,
        PH_SEAL = 2'd2
    } phase_e;

    typedef struct packed {
        logic  load;
        logic  stack;
        addr_t sp_next;
    } op_t;

    // number of registers covered by a range that may wrap
    function automatic cnt_t span_of(idx_t lo, idx_t hi);
        int d;
        if (int'(hi) >= int'(lo)) d = int'(hi) - int'(lo);
        else                      d = int'(hi) + NREG - int'(lo);
        return cnt_t'(d + 1);
    endfunction

    function automatic addr_t bytes_of(cnt_t n);
        return addr_t'(n) * addr_t'(WORD_BYTES);
    endfunction

    function automatic idx_t next_idx(idx_t i);
        if (int'(i) == NREG - 1) return '0;
        return i + idx_t'(1);
    endfunction
endpackage

// File: rtl/lsm_plan.sv
module lsm_plan
    import lsm_pkg::*;
(
    input  logic  is_load,
    input  idx_t  base_sel,
    input  idx_t  first_idx,
    input  idx_t  last_idx,
    input  addr_t base_val,
    input  addr_t offset,
    input  addr_t sp_val,
    output cnt_t  count,
    output addr_t start_addr,
    output op_t   op
);
    addr_t span_bytes;
    addr_t sp_below;
    addr_t sp_above;
    logic  use_stack;

    always_comb begin
        count      = span_of(first_idx, last_idx);
        span_bytes = bytes_of(count);
        sp_below   = sp_val - span_bytes;
        sp_above   = sp_val + span_bytes;
        use_stack  = (base_sel == '0);

        if (!use_stack)   start_addr = base_val + offset;
        else if (is_load) start_addr = sp_below;
        else              start_addr = sp_val;

        op.load    = is_load;
        op.stack   = use_stack;
        op.sp_next = is_load ? sp_below : sp_above;
    end
endmodule

// File: rtl/lsm_walk.sv
module lsm_walk
    import lsm_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load_en,
    input  idx_t  first_idx,
    input  addr_t start_addr,
    input  logic  step,
    output idx_t  idx,
    output addr_t addr
);
    idx_t  idx_q;
    addr_t addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q  <= '0;
            addr_q <= '0;
        end else if (load_en) begin
            idx_q  <= first_idx;
            addr_q <= start_addr;
        end else if (step) begin
            idx_q  <= next_idx(idx_q);
            addr_q <= addr_q + addr_t'(WORD_BYTES);
        end
    end

    assign idx  = idx_q;
    assign addr = addr_q;
endmodule

// File: rtl/lsm_ctrl.sv
module lsm_ctrl
    import lsm_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  cnt_t   count,
    input  logic   ack,
    output logic   accept,
    output logic   step,
    output phase_e phase,
    output logic   busy,
    output logic   done
);
    phase_e ph_q;
    cnt_t   left_q;
    logic   final_beat;

    assign accept     = start && (ph_q == PH_IDLE);
    assign step       = (ph_q == PH_MOVE) && ack;
    assign final_beat = step && (left_q == cnt_t'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= PH_IDLE;
            left_q <= '0;
        end else begin
            case (ph_q)
                PH_IDLE: if (accept) begin
                    ph_q   <= PH_MOVE;
                    left_q <= count;
                end
                PH_MOVE: if (step) begin
                    left_q <= left_q - cnt_t'(1);
                    if (final_beat) ph_q <= PH_SEAL;
                end
                PH_SEAL: ph_q <= PH_IDLE;
                default: ph_q <= PH_IDLE;
            endcase
        end
    end

    assign phase = ph_q;
    assign busy  = (ph_q != PH_IDLE);
    assign done  = (ph_q == PH_SEAL);
endmodule

// File: rtl/lsm_seq.sv
module lsm_seq
    import lsm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              is_load,
    input  logic [IDX_W-1:0]  first_idx,
    input  logic [IDX_W-1:0]  last_idx,
    input  logic [IDX_W-1:0]  base_sel,
    input  logic [AW-1:0]     base_val,
    input  logic [AW-1:0]     offset,
    input  logic [AW-1:0]     sp_val,
    output logic              busy,
    output logic              done,
    output logic              sp_we,
    output logic [AW-1:0]     sp_wdata,
    output logic [IDX_W-1:0]  rf_raddr,
    input  logic [DW-1:0]     rf_rdata,
    output logic              rf_we,
    output logic [IDX_W-1:0]  rf_waddr,
    output logic [DW-1:0]     rf_wdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [DW-1:0]     mem_wdata,
    input  logic [DW-1:0]     mem_rdata,
    input  logic              mem_ack
);
    cnt_t   count;
    addr_t  start_addr;
    op_t    op_in;
    op_t    op_q;
    logic   accept;
    logic   step;
    phase_e phase;
    idx_t   cur_idx;
    addr_t  cur_addr;

    lsm_plan u_plan (
        .is_load    (is_load),
        .base_sel   (base_sel),
        .first_idx  (first_idx),
        .last_idx   (last_idx),
        .base_val   (base_val),
        .offset     (offset),
        .sp_val     (sp_val),
        .count      (count),
        .start_addr (start_addr),
        .op         (op_in)
    );

    lsm_ctrl u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .count  (count),
        .ack    (mem_ack),
        .accept (accept),
        .step   (step),
        .phase  (phase),
        .busy   (busy),
        .done   (done)
    );

    lsm_walk u_walk (
        .clk        (clk),
        .rst        (rst),
        .load_en    (accept),
        .first_idx  (first_idx),
        .start_addr (start_addr),
        .step       (step),
        .idx        (cur_idx),
        .addr       (cur_addr)
    );

    always_ff @(posedge clk) begin
        if (rst)         op_q <= '0;
        else if (accept) op_q <= op_in;
    end

    assign mem_req   = (phase == PH_MOVE);
    assign mem_we    = mem_req && !op_q.load;
    assign mem_addr  = cur_addr;
    assign mem_wdata = rf_rdata;
    assign rf_raddr  = cur_idx;
    assign rf_waddr  = cur_idx;
    assign rf_we     = step && op_q.load;
    assign rf_wdata  = mem_rdata;
    assign sp_we     = done && op_q.stack;
    assign sp_wdata  = op_q.sp_next;
endmodule

// File: rtl/lsm_seq_chk.sv
module lsm_seq_chk
    import lsm_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input logic  busy,
    input logic  done,
    input logic  sp_we,
    input logic  rf_we,
    input logic  mem_req,
    input logic  mem_we,
    input logic  mem_ack,
    input addr_t mem_addr
);
    a_r6_hold_request: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    a_r2_address_step: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_ack) |=> (!mem_req || (mem_addr == $past(mem_addr) + addr_t'(WORD_BYTES))));

    a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r7_sp_only_at_done: assert property (@(posedge clk) disable iff (rst)
        sp_we |-> done);

    a_r9_rf_write_on_ack: assert property (@(posedge clk) disable iff (rst)
        rf_we |-> (mem_req && mem_ack && !mem_we));

    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mem_req && !rf_we && !done));
endmodule

bind lsm_seq lsm_seq_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .busy     (busy),
    .done     (done),
    .sp_we    (sp_we),
    .rf_we    (rf_we),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_ack  (mem_ack),
    .mem_addr (mem_addr)
);

// File: tb/lsm_seq_bench.sv
module lsm_seq_bench;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic        ld;
        logic [3:0]  first;
        logic [3:0]  last;
        logic [3:0]  bsel;
        logic [31:0] base;
        logic [31:0] off;
        logic [31:0] sp;
        logic [4:0]  cnt;
        logic [31:0] addr;
        logic [31:0] spx;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VT [NV] = '{
        '{1'b0, 4'd2,  4'd5,  4'd3, 32'h100, 32'h20,       32'h800, 5'd4,  32'h120, 32'h800},
        '{1'b1, 4'd0,  4'd15, 4'd1, 32'h200, 32'h4,        32'h800, 5'd16, 32'h204, 32'h800},
        '{1'b0, 4'd4,  4'd6,  4'd0, 32'h0,   32'h999,      32'h300, 5'd3,  32'h300, 32'h30C},
        '{1'b1, 4'd4,  4'd6,  4'd0, 32'h0,   32'h777,      32'h30C, 5'd3,  32'h300, 32'h300},
        '{1'b0, 4'd14, 4'd1,  4'd0, 32'h0,   32'h0,        32'h402, 5'd4,  32'h402, 32'h412},
        '{1'b1, 4'd14, 4'd1,  4'd0, 32'h0,   32'h40,       32'h412, 5'd4,  32'h402, 32'h402},
        '{1'b0, 4'd7,  4'd7,  4'd0, 32'h0,   32'h8,        32'h500, 5'd1,  32'h500, 32'h504},
        '{1'b1, 4'd9,  4'd8,  4'd2, 32'h600, 32'hFFFFFFFC, 32'h800, 5'd16, 32'h5FC, 32'h800}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        is_load = 1'b0;
    logic [3:0]  first_idx = '0;
    logic [3:0]  last_idx = '0;
    logic [3:0]  base_sel = '0;
    logic [31:0] base_val = '0;
    logic [31:0] offset = '0;
    logic [31:0] sp_val = '0;
    logic        busy, done, sp_we, rf_we, mem_req, mem_we;
    logic [31:0] sp_wdata, rf_wdata, mem_addr, mem_wdata;
    logic [3:0]  rf_raddr, rf_waddr;
    logic [31:0] rf_rdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;

    logic [31:0] rf  [16];
    logic [31:0] mem [1024];

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    int lat = 0;
    int wcnt = 0;
    int beats = 0;
    int seq_err = 0;
    int stab_err = 0;
    int done_cnt = 0;
    int sp_writes = 0;
    logic [31:0] hold_addr = '0;
    logic [31:0] exp_start = '0;
    logic [3:0]  exp_first = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lsm_seq u_lsm_seq (
        .clk(clk), .rst(rst), .start(start), .is_load(is_load),
        .first_idx(first_idx), .last_idx(last_idx), .base_sel(base_sel),
        .base_val(base_val), .offset(offset), .sp_val(sp_val),
        .busy(busy), .done(done), .sp_we(sp_we), .sp_wdata(sp_wdata),
        .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .rf_we(rf_we),
        .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    assign rf_rdata = rf[rf_raddr];

    always @(posedge clk) begin
        if (rf_we) rf[rf_waddr] <= rf_wdata;
        if (sp_we) sp_val <= sp_wdata;
    end

    // memory model and beat monitor, evaluated away from the active edge
    always @(negedge clk) begin
        cycles = cycles + 1;
        if (done) done_cnt = done_cnt + 1;
        if (sp_we) sp_writes = sp_writes + 1;
        if (rst) begin
            mem_ack = 1'b0;
            wcnt = 0;
        end else if (mem_ack) begin
            mem_ack = 1'b0;
            wcnt = 0;
        end else if (mem_req) begin
            if (wcnt == 0) hold_addr = mem_addr;
            else if (mem_addr != hold_addr) stab_err = stab_err + 1;
            if (wcnt >= lat) begin
                if (mem_addr != exp_start + 32'(4 * beats)) seq_err = seq_err + 1;
                if (rf_raddr != 4'(int'(exp_first) + beats)) seq_err = seq_err + 1;
                mem_rdata = mem[mem_addr[11:2]];
                if (mem_we) mem[mem_addr[11:2]] = mem_wdata;
                mem_ack = 1'b1;
                beats = beats + 1;
            end else begin
                wcnt = wcnt + 1;
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // launches one transfer; poke pulses a second start mid-flight
    task automatic run_op(input vec_t v, input int l, input bit poke, input string tag);
        int t;
        lat = l; beats = 0; seq_err = 0; stab_err = 0; done_cnt = 0; sp_writes = 0;
        exp_start = v.addr; exp_first = v.first;
        @(negedge clk);
        is_load = v.ld; first_idx = v.first; last_idx = v.last; base_sel = v.bsel;
        base_val = v.base; offset = v.off; sp_val = v.sp; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        t = 0;
        while (done_cnt == 0 && t < 2000) begin
            @(negedge clk);
            t = t + 1;
            if (poke && t == 4) begin
                is_load = ~v.ld; first_idx = 4'd3; last_idx = 4'd3; base_sel = 4'd0;
                start = 1'b1;
            end else begin
                start = 1'b0;
            end
        end
        repeat (3) @(negedge clk);
        check(t < 2000, "R7", {tag, " completion"}, 32'(t), 32'd0);
        check(beats == int'(v.cnt), "R1", {tag, " beat count"}, 32'(beats), 32'(v.cnt));
        check(seq_err == 0, "R2", {tag, " address/index order"}, 32'(seq_err), 32'd0);
        check(stab_err == 0, "R6", {tag, " request held"}, 32'(stab_err), 32'd0);
        check(done_cnt == 1, "R7", {tag, " done width"}, 32'(done_cnt), 32'd1);
        check(sp_val == v.spx, v.bsel == 0 ? (v.ld ? "R4" : "R3") : "R2",
              {tag, " stack pointer"}, sp_val, v.spx);
        check(sp_writes == (v.bsel == 0 ? 1 : 0), "R7", {tag, " pointer writes"},
              32'(sp_writes), 32'(v.bsel == 0 ? 1 : 0));
        check(rf[v.first] == mem[v.addr[11:2]], "R9", {tag, " first word"},
              rf[v.first], mem[v.addr[11:2]]);
        check(rf[v.last] == mem[10'((v.addr + 32'(4 * (int'(v.cnt) - 1))) >> 2)], "R9",
              {tag, " last word"}, rf[v.last],
              mem[10'((v.addr + 32'(4 * (int'(v.cnt) - 1))) >> 2)]);
        check(!busy && !mem_req, "R11", {tag, " idle after"}, {30'd0, busy, mem_req}, 32'd0);
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = 32'h5EED_0000 ^ 32'(i);
        for (int i = 0; i < 16; i++) rf[i] = 32'hA000_0000 + 32'(i);
        repeat (3) @(negedge clk);
        // R11: reset state
        check(!busy && !mem_req && !done && !sp_we && !rf_we, "R11", "reset outputs",
              {27'd0, busy, mem_req, done, sp_we, rf_we}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !mem_req, "R11", "idle after reset release",
              {30'd0, busy, mem_req}, 32'd0);

        // table walk: R1 R2 R3 R4 R5 R8 R9
        for (int v = 0; v < NV; v++) begin
            for (int i = 0; i < 16; i++) rf[i] = 32'hC0DE_0000 + 32'(v * 256 + i);
            run_op(VT[v], v % 3, 1'b0, $sformatf("vec%0d", v));
        end
        // R8: unaligned push/pop (vec4/vec5) kept low address bits
        check(VT[4].addr[1:0] == 2'b10, "R8", "unaligned case present", 32'(VT[4].addr), 32'h402);

        // R10: start during a running push is ignored
        run_op('{1'b0, 4'd0, 4'd15, 4'd0, 32'h0, 32'h0, 32'h700, 5'd16, 32'h700, 32'h740},
               1, 1'b1, "R10 busy start");
        repeat (10) @(negedge clk);
        check(!mem_req && sp_val == 32'h740, "R10", "no follow-on transfer", sp_val, 32'h740);

        // R5: offset has no effect in stack mode, different offsets same result
        run_op('{1'b0, 4'd1, 4'd2, 4'd0, 32'h0, 32'hABCD, 32'h900, 5'd2, 32'h900, 32'h908},
               0, 1'b0, "R5 offset ignored");

        // R11: reset in mid-transfer
        lat = 2; beats = 0; done_cnt = 0; sp_writes = 0;
        exp_start = 32'hA00; exp_first = 4'd0;
        @(negedge clk);
        is_load = 1'b0; first_idx = 4'd0; last_idx = 4'd15; base_sel = 4'd0;
        sp_val = 32'hA00; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (6) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        check(!busy && !mem_req && done_cnt == 0 && sp_writes == 0 && sp_val == 32'hA00,
              "R11", "reset mid-transfer", sp_val, 32'hA00);

        finish_run();
    end

    initial begin
        while (cycles < 150000) @(negedge clk);
        errors = errors + 1;
        checks = checks + 1;
        $display("FAIL watchdog: actual=%0d expected<150000", cycles);
        finish_run();
    end
endmodule